// File: doc/BRIEF.md
# SIR Infrared Pulse Modem

This block sits between a byte-wide transmit/receive interface and an infrared transceiver that carries slow-rate IrDA pulses. On the transmit side it serialises a byte into a ten-cell frame. Each zero cell is sent as a short light pulse and each one cell is sent as darkness. The pulse is either a fixed number of clocks or three sixteenths of a bit cell. On the receive side a digital detector confirms a pulse only after a programmable run of consecutive active samples. The framer then rebuilds the byte from the cells that held a confirmed pulse.

A 9-bit divisor sets the rate. A sample tick fires once every divisor+1 clocks, and a bit cell lasts sixteen ticks. With an input clock of 16 × rate × (divisor+1), the divisors 0x009, 0x013, 0x01D, 0x03B, 0x077 and 0x1DF give 115.2k, 57.6k, 38.4k, 19.2k, 9.6k and 2.4k. Further controls invert the receive sense and the transmit pin, pick one of two receive inputs, and power down each direction on its own. A soft reset returns both directions to idle.

Top module: `sir_pulse_modem`

## Requirements
- R1: After reset `ir_tx` equals `cfg_tx_inv`, and `tx_busy`, `rx_valid` and `rx_frame_err` are 0.
- R2: A sample tick occurs every `cfg_div`+1 clocks. A bit cell is 16 ticks, so zero-cell pulses of a frame start 16×(`cfg_div`+1) clocks apart.
- R3: A frame is one start cell (0), eight data cells sent LSB first, and one stop cell (1). A zero cell carries one pulse and a one cell carries none. `tx_busy` rises the cycle after an accepted `tx_start` and falls after the stop cell.
- R4: With `cfg_wide` = 0, each pulse is active for exactly FIXED_PULSE_CLK clocks (default 30).
- R5: With `cfg_wide` = 1, each pulse is active for 3 ticks, which is 3×(`cfg_div`+1) clocks.
- R6: A receive pulse is confirmed only after N consecutive active samples, one per clock. N = 4×(code+1) for `cfg_sens` codes 0 to 6, and code 7 behaves as code 6 (N = 28). A pulse of N−1 samples is ignored.
- R7: A confirmed pulse inside a cell decodes that cell as 0 and an empty cell as 1. A good frame gives a one-cycle `rx_valid` with the byte on `rx_data`.
- R8: A pulse in the stop cell gives a one-cycle `rx_frame_err`, and no `rx_valid` is raised for that frame.
- R9: The sampled receive input is active high when `cfg_rx_inv` = 0 and active low when `cfg_rx_inv` = 1.
- R10: `cfg_tx_inv` = 1 inverts `ir_tx`, so that idle is 1 and pulses are 0.
- R11: `cfg_rx_sel` = 1 takes `ir_rx_slow` and 0 takes `ir_rx_fast`. The input not selected has no effect.
- R12: While `cfg_tx_pd` = 1, `ir_tx` stays at its idle level and `tx_start` is ignored (`tx_busy` stays 0).
- R13: While `cfg_rx_pd` = 1, neither `rx_valid` nor `rx_frame_err` is raised.
- R14: A `soft_rst` pulse aborts a frame in progress: `tx_busy` is 0 and `ir_tx` is idle on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous reset of both directions |
| cfg_div | input | 9 | Rate divisor; tick every cfg_div+1 clocks |
| cfg_sens | input | 3 | Pulse-confirm sensitivity code |
| cfg_wide | input | 1 | 1: pulse of 3/16 cell, 0: fixed pulse |
| cfg_rx_inv | input | 1 | Receive input active low when 1 |
| cfg_tx_inv | input | 1 | Invert transmit pin |
| cfg_rx_sel | input | 1 | 1: slow input, 0: fast input |
| cfg_tx_pd | input | 1 | Transmitter power-down |
| cfg_rx_pd | input | 1 | Receiver power-down |
| tx_start | input | 1 | Request to send tx_data |
| tx_data | input | 8 | Byte to send |
| tx_busy | output | 1 | Frame in progress |
| ir_tx | output | 1 | Optical transmit pin |
| ir_rx_fast | input | 1 | Receive input, fast path |
| ir_rx_slow | input | 1 | Receive input, slow path |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_frame_err | output | 1 | One-cycle strobe for a bad stop cell |

## Verification
The transmitter and the receiver share one tick generator. Both can be active in the same cycles, in which case a transmit pulse edge and a receive confirmation or window close fall on the same tick. The bench provokes this by sending one byte out on `ir_tx` while it drives a different byte into the slow input over the same frame time. It then checks both the pulse count on the pin and the received byte. Loopback runs at three divisors and with both polarities inverted, which exercises confirmations that land close to the tick where a receive window closes.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int WIDE_TICKS    = 3;
  localparam int FRAME_BITS    = 10;
  localparam int HALF_TICKS    = TICKS_PER_BIT / 2;

  typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_RUN} tx_state_t;
  typedef enum logic [1:0] {RX_IDLE, RX_HALF, RX_DATA, RX_STOP} rx_state_t;

  // consecutive active samples needed for a confirmed pulse
  function automatic logic [4:0] sens_threshold(input logic [2:0] code);
    if (code == 3'd7) return 5'd28;
    return {code, 2'b00} + 5'd4;
  endfunction
endpackage

// File: rtl/sir_tick_gen.sv
module sir_tick_gen #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sir_tx.sv
module sir_tx #(
  parameter int FIXED_PULSE_CLK = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       pd,
  input  logic       inv,
  input  logic       wide,
  input  logic       start,
  input  logic [7:0] data,
  output logic       busy,
  output logic       ir_tx
);
  import sir_pkg::*;
  localparam int PCW = $clog2(FIXED_PULSE_CLK + 1);

  tx_state_t               st;
  logic [FRAME_BITS-1:0]   sh;
  logic [3:0]              bitn;
  logic [3:0]              tc;
  logic                    pulse;
  logic [PCW-1:0]          pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TX_IDLE; sh <= '0; bitn <= '0; tc <= '0;
      pulse <= 1'b0; pcnt <= '0; busy <= 1'b0; ir_tx <= inv;
    end else begin
      ir_tx <= (pulse & ~pd) ^ inv;
      // pulse end; a new pulse start below takes precedence
      if (pulse) begin
        if (wide) begin
          if (tick && tc == 4'(WIDE_TICKS - 1)) pulse <= 1'b0;
        end else if (pcnt == '0) pulse <= 1'b0;
        else pcnt <= pcnt - 1'b1;
      end
      if (pd) begin
        st <= TX_IDLE; busy <= 1'b0; pulse <= 1'b0;
      end else begin
        case (st)
          TX_IDLE: if (start) begin
            sh   <= {1'b1, data, 1'b0};
            bitn <= '0;
            busy <= 1'b1;
            st   <= TX_ARM;
          end
          TX_ARM: if (tick) begin
            st <= TX_RUN;
            tc <= '0;
            if (!sh[0]) begin
              pulse <= 1'b1;
              pcnt  <= PCW'(FIXED_PULSE_CLK - 1);
            end
          end
          TX_RUN: if (tick) begin
            if (tc == 4'(TICKS_PER_BIT - 1)) begin
              tc <= '0;
              if (bitn == 4'(FRAME_BITS - 1)) begin
                st   <= TX_IDLE;
                busy <= 1'b0;
              end else begin
                sh   <= sh >> 1;
                bitn <= bitn + 1'b1;
                if (!sh[1]) begin
                  pulse <= 1'b1;
                  pcnt  <= PCW'(FIXED_PULSE_CLK - 1);
                end
              end
            end else tc <= tc + 1'b1;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sir_rx.sv
module sir_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       pd,
  input  logic       inv,
  input  logic       sel,
  input  logic [2:0] sens,
  input  logic       rx_fast,
  input  logic       rx_slow,
  output logic [7:0] data,
  output logic       valid,
  output logic       ferr
);
  import sir_pkg::*;

  logic       s1, s2, active, conf, zero_seen, zs;
  logic [4:0] run, thr;
  logic [3:0] tc;
  logic [2:0] bitn;
  logic [7:0] sh;
  rx_state_t  st;

  assign active = s2 ^ inv;
  assign thr    = sens_threshold(sens);
  assign zs     = zero_seen | conf;

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      s1 <= 1'b0; s2 <= 1'b0; run <= '0; conf <= 1'b0;
      st <= RX_IDLE; tc <= '0; bitn <= '0; sh <= '0; zero_seen <= 1'b0;
      data <= '0; valid <= 1'b0; ferr <= 1'b0;
    end else begin
      s1    <= sel ? rx_slow : rx_fast;
      s2    <= s1;
      run   <= active ? ((run == 5'd31) ? run : run + 1'b1) : 5'd0;
      conf  <= active && (run == thr - 5'd1);
      valid <= 1'b0;
      ferr  <= 1'b0;
      case (st)
        RX_IDLE: if (conf) begin
          st <= RX_HALF; tc <= '0;
        end
        RX_HALF: if (tick) begin
          if (tc == 4'(HALF_TICKS - 1)) begin
            st <= RX_DATA; tc <= '0; bitn <= '0; zero_seen <= 1'b0;
          end else tc <= tc + 1'b1;
        end
        RX_DATA, RX_STOP: begin
          zero_seen <= zs;
          if (tick) begin
            if (tc == 4'(TICKS_PER_BIT - 1)) begin
              tc        <= '0;
              zero_seen <= 1'b0;
              if (st == RX_DATA) begin
                sh <= {~zs, sh[7:1]};
                if (bitn == 3'd7) st <= RX_STOP;
                else bitn <= bitn + 1'b1;
              end else begin
                st <= RX_IDLE;
                if (zs) ferr <= 1'b1;
                else begin
                  valid <= 1'b1;
                  data  <= sh;
                end
              end
            end else tc <= tc + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sir_pulse_modem.sv
module sir_pulse_modem #(
  parameter int DIV_W           = 9,
  parameter int FIXED_PULSE_CLK = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [2:0]       cfg_sens,
  input  logic             cfg_wide,
  input  logic             cfg_rx_inv,
  input  logic             cfg_tx_inv,
  input  logic             cfg_rx_sel,
  input  logic             cfg_tx_pd,
  input  logic             cfg_rx_pd,
  input  logic             tx_start,
  input  logic [7:0]       tx_data,
  output logic             tx_busy,
  output logic             ir_tx,
  input  logic             ir_rx_fast,
  input  logic             ir_rx_slow,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_frame_err
);
  logic rst_i, tick;
  assign rst_i = rst | soft_rst;

  sir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst_i), .div(cfg_div), .tick(tick)
  );

  sir_tx #(.FIXED_PULSE_CLK(FIXED_PULSE_CLK)) u_tx (
    .clk(clk), .rst(rst_i), .tick(tick), .pd(cfg_tx_pd), .inv(cfg_tx_inv),
    .wide(cfg_wide), .start(tx_start), .data(tx_data),
    .busy(tx_busy), .ir_tx(ir_tx)
  );

  sir_rx u_rx (
    .clk(clk), .rst(rst_i), .tick(tick), .pd(cfg_rx_pd), .inv(cfg_rx_inv),
    .sel(cfg_rx_sel), .sens(cfg_sens), .rx_fast(ir_rx_fast),
    .rx_slow(ir_rx_slow), .data(rx_data), .valid(rx_valid),
    .ferr(rx_frame_err)
  );
endmodule

// File: rtl/sir_pulse_modem_chk.sv
module sir_pulse_modem_chk (
  input logic clk,
  input logic rst,
  input logic soft_rst,
  input logic cfg_tx_pd,
  input logic cfg_rx_pd,
  input logic cfg_tx_inv,
  input logic tx_start,
  input logic tx_busy,
  input logic ir_tx,
  input logic rx_valid,
  input logic rx_frame_err
);
  a_r8_valid_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_frame_err));

  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (tx_start && !tx_busy && !cfg_tx_pd && !soft_rst) |=> tx_busy);

  a_r12_pd_pin_idle: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_tx_pd) |-> (ir_tx == $past(cfg_tx_inv)));

  a_r12_pd_not_busy: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_tx_pd) |-> !tx_busy);

  a_r13_rx_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rx_pd) |-> (!rx_valid && !rx_frame_err));

  a_r14_soft_abort: assert property (@(posedge clk) disable iff (rst)
    $past(soft_rst) |-> !tx_busy);
endmodule

bind sir_pulse_modem sir_pulse_modem_chk u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_tx_pd(cfg_tx_pd),
  .cfg_rx_pd(cfg_rx_pd), .cfg_tx_inv(cfg_tx_inv), .tx_start(tx_start),
  .tx_busy(tx_busy), .ir_tx(ir_tx), .rx_valid(rx_valid),
  .rx_frame_err(rx_frame_err)
);

// File: tb/sir_pulse_modem_bench.sv
`timescale 1ns/1ps
module sir_pulse_modem_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1, soft_rst = 1'b0;
  logic [8:0] cfg_div = 9'd9;
  logic [2:0] cfg_sens = 3'd0;
  logic       cfg_wide = 0, cfg_rx_inv = 0, cfg_tx_inv = 0, cfg_rx_sel = 0;
  logic       cfg_tx_pd = 0, cfg_rx_pd = 0;
  logic       tx_start = 0;
  logic [7:0] tx_data = '0;
  logic       tx_busy, ir_tx, rx_valid, rx_frame_err;
  logic [7:0] rx_data;
  logic       lb = 1'b1, rxf_r = 1'b0, rxs_r = 1'b0;
  wire        ir_rx_fast = lb ? ir_tx : rxf_r;

  sir_pulse_modem u_sir_pulse_modem (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_div(cfg_div),
    .cfg_sens(cfg_sens), .cfg_wide(cfg_wide), .cfg_rx_inv(cfg_rx_inv),
    .cfg_tx_inv(cfg_tx_inv), .cfg_rx_sel(cfg_rx_sel), .cfg_tx_pd(cfg_tx_pd),
    .cfg_rx_pd(cfg_rx_pd), .tx_start(tx_start), .tx_data(tx_data),
    .tx_busy(tx_busy), .ir_tx(ir_tx), .ir_rx_fast(ir_rx_fast),
    .ir_rx_slow(rxs_r), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err)
  );

  int errors = 0, checks = 0;
  int cyc = 0, rises = 0, width = 0, intv = 0, rise_t = 0;
  int rx_n = 0, ferr_n = 0;
  logic [7:0] rx_last = '0;
  logic prev_lvl = 1'b0, have_rise = 1'b0;

  always @(negedge clk) begin
    logic lvl;
    cyc++;
    lvl = ir_tx ^ cfg_tx_inv;
    if (lvl && !prev_lvl) begin
      rises++;
      if (have_rise) intv = cyc - rise_t;
      rise_t = cyc; have_rise = 1'b1;
    end
    if (!lvl && prev_lvl) width = cyc - rise_t;
    prev_lvl = lvl;
    if (rx_valid) begin rx_n++; rx_last = rx_data; end
    if (rx_frame_err) ferr_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_mon();
    idle(3);
    rises = 0; have_rise = 1'b0; width = 0; intv = 0;
  endtask

  function automatic int zeros(input logic [7:0] b);
    int z = 1;
    for (int i = 0; i < 8; i++) if (!b[i]) z++;
    return z;
  endfunction

  task automatic send_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    for (int i = 0; i < 6000 && tx_busy; i++) @(negedge clk);
    idle(40);
  endtask

  task automatic drive_frame(input bit slow, input logic [7:0] b, input bit bad_stop,
                             input int plen, input int bclk);
    logic [9:0] f;
    f = {~bad_stop, b, 1'b0};
    for (int i = 0; i < 10; i++)
      for (int c = 0; c < bclk; c++) begin
        @(negedge clk);
        if (slow) rxs_r = (!f[i] && c < plen) ^ cfg_rx_inv;
        else      rxf_r = (!f[i] && c < plen) ^ cfg_rx_inv;
      end
    @(negedge clk); rxs_r = cfg_rx_inv; rxf_r = cfg_rx_inv;
    idle(40);
  endtask

  task automatic t_reset();
    idle(2);
    chk(ir_tx == cfg_tx_inv, "R1 ir_tx idle", ir_tx, cfg_tx_inv);
    chk(!tx_busy && !rx_valid && !rx_frame_err, "R1 strobes low", tx_busy, 0);
  endtask

  task automatic t_loop_fixed();
    int n0;
    lb = 1; cfg_div = 9; cfg_wide = 0; clr_mon(); n0 = rx_n;
    send_tx(8'hA5);
    chk(rx_n == n0 + 1 && rx_last == 8'hA5, "R7 loopback byte", rx_last, 8'hA5);
    chk(rises == zeros(8'hA5), "R3 pulse count", rises, zeros(8'hA5));
    chk(width == 30, "R4 fixed width", width, 30);
  endtask

  task automatic t_wide();
    int n0;
    cfg_div = 11; cfg_wide = 1; clr_mon(); n0 = rx_n;
    send_tx(8'h00);
    chk(width == 36, "R5 wide width", width, 36);
    chk(rx_n == n0 + 1 && rx_last == 8'h00, "R5 wide rx", rx_last, 0);
    cfg_wide = 0;
  endtask

  task automatic t_rate();
    cfg_div = 3; clr_mon();
    send_tx(8'h00);
    chk(intv == 64, "R2 cell spacing", intv, 64);
    chk(rises == 9, "R3 all-zero pulses", rises, 9);
    cfg_div = 9; clr_mon();
    send_tx(8'hFF);
    chk(rises == 1, "R3 start pulse only", rises, 1);
    chk(rx_last == 8'hFF, "R7 all ones", rx_last, 8'hFF);
  endtask

  task automatic t_sens();
    int n0;
    lb = 0; cfg_div = 9;
    cfg_sens = 1; n0 = rx_n;
    drive_frame(0, 8'h5A, 0, 7, 160);
    chk(rx_n == n0, "R6 code1 short ignored", rx_n - n0, 0);
    drive_frame(0, 8'h5A, 0, 8, 160);
    chk(rx_n == n0 + 1 && rx_last == 8'h5A, "R6 code1 exact", rx_last, 8'h5A);
    cfg_sens = 7; n0 = rx_n;
    drive_frame(0, 8'h69, 0, 27, 160);
    chk(rx_n == n0, "R6 code7 short ignored", rx_n - n0, 0);
    drive_frame(0, 8'h69, 0, 28, 160);
    chk(rx_n == n0 + 1 && rx_last == 8'h69, "R6 code7 as 28", rx_last, 8'h69);
    cfg_sens = 0;
  endtask

  task automatic t_ferr();
    int n0, f0;
    n0 = rx_n; f0 = ferr_n;
    drive_frame(0, 8'h33, 1, 10, 160);
    chk(ferr_n == f0 + 1, "R8 frame error", ferr_n - f0, 1);
    chk(rx_n == n0, "R8 byte dropped", rx_n - n0, 0);
  endtask

  task automatic t_sel();
    int n0;
    cfg_rx_sel = 1; n0 = rx_n;
    drive_frame(1, 8'h96, 0, 20, 160);
    chk(rx_n == n0 + 1 && rx_last == 8'h96, "R11 slow selected", rx_last, 8'h96);
    cfg_rx_sel = 0; n0 = rx_n;
    drive_frame(1, 8'h96, 0, 20, 160);
    chk(rx_n == n0, "R11 slow unselected", rx_n - n0, 0);
  endtask

  task automatic t_pol();
    int n0;
    lb = 1; cfg_tx_inv = 1; cfg_rx_inv = 1; clr_mon(); n0 = rx_n;
    chk(ir_tx == 1'b1, "R10 inverted idle", ir_tx, 1);
    send_tx(8'hC3);
    chk(rx_n == n0 + 1 && rx_last == 8'hC3, "R9 inverted loopback", rx_last, 8'hC3);
    chk(rises == zeros(8'hC3), "R10 inverted pulses", rises, zeros(8'hC3));
    cfg_tx_inv = 0; cfg_rx_inv = 0; rxf_r = 0; rxs_r = 0; idle(20);
  endtask

  task automatic t_pd();
    int n0;
    cfg_tx_pd = 1; clr_mon();
    @(negedge clk); tx_data = 8'h00; tx_start = 1;
    @(negedge clk); tx_start = 0;
    idle(400);
    chk(!tx_busy && rises == 0, "R12 start ignored", rises, 0);
    cfg_tx_pd = 0; cfg_rx_pd = 1; clr_mon(); n0 = rx_n;
    send_tx(8'h12);
    chk(rx_n == n0, "R13 receiver off", rx_n - n0, 0);
    chk(rises == zeros(8'h12), "R13 tx unaffected", rises, zeros(8'h12));
    cfg_rx_pd = 0; idle(20);
  endtask

  task automatic t_soft();
    @(negedge clk); tx_data = 8'h00; tx_start = 1;
    @(negedge clk); tx_start = 0;
    idle(200);
    chk(tx_busy, "R14 busy before", tx_busy, 1);
    soft_rst = 1; @(negedge clk); soft_rst = 0; @(negedge clk);
    chk(!tx_busy && ir_tx == cfg_tx_inv, "R14 aborted", tx_busy, 0);
    idle(2000);
  endtask

  task automatic t_duplex();
    int n0;
    lb = 0; cfg_rx_sel = 1; clr_mon(); n0 = rx_n;
    fork
      send_tx(8'h3C);
      drive_frame(1, 8'hC3, 0, 20, 160);
    join
    chk(rx_n == n0 + 1 && rx_last == 8'hC3, "R7 duplex rx", rx_last, 8'hC3);
    chk(rises == zeros(8'h3C), "R3 duplex tx", rises, zeros(8'h3C));
    cfg_rx_sel = 0; lb = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    idle(5); rst = 0;
    t_reset();
    t_loop_fixed();
    t_wide();
    t_rate();
    t_sens();
    t_ferr();
    t_sel();
    t_pol();
    t_pd();
    t_soft();
    t_duplex();
    finish_run();
  end

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end
endmodule